// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block shapes the read/write strobe of a single programmed-I/O data transfer on an ATA bus. One timing byte describes the cycle. Its upper nibble holds the length of the active phase and its lower nibble holds the length of the recovery phase. Each phase lasts the field value plus one system clock. At 30 MHz one clock is about 33.33 ns, so every step of a field adds that much to the phase.

A configuration bit picks where the timing comes from. When the bit is set, the block uses the byte on its timing input. When the bit is clear, it uses a built-in default byte of 0x5C, which gives an active phase of 6 clocks and a recovery phase of 13 clocks. Typical programmed values by transfer mode are 0x5C, 0x37, 0x33, 0x22 and 0x20, for mode 0 through mode 4.

A surrounding controller raises a start request while the block is idle. The block then drives the strobe through both phases, holds busy for the whole cycle, and pulses done on the last recovery clock. It is ready again on the clock that follows done.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is applied, and after it is released with no start request, strobe_o, busy_o and done_o are all 0.
- R2: A start request (start_i = 1) seen at a clock edge while busy_o is 0 is accepted. On the next clock strobe_o and busy_o are both 1.
- R3: strobe_o is 1 (the active level) for exactly bits [7:4] of the selected timing byte plus one clocks.
- R4: After the active phase, strobe_o is 0 for exactly bits [3:0] of the selected timing byte plus one clocks before the cycle ends.
- R5: With use_prog_i = 1 the selected timing byte is timing_i. With use_prog_i = 0 it is the default byte 0x5C (active 6 clocks, recovery 13 clocks), whatever timing_i holds.
- R6: timing_i and use_prog_i are sampled only at the edge where a start is accepted. Changes made during a cycle do not alter that cycle.
- R7: busy_o is 1 from the clock after acceptance through the last recovery clock. A start request made while busy_o is 1 is ignored and starts no further cycle.
- R8: done_o is 1 for exactly one clock, on the last recovery clock. On the next clock busy_o is 0, and a start request made in that clock is accepted, so the next strobe rises two clocks after done.
- R9: A field value of 0 gives a phase of exactly one clock. No phase is ever shorter than one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request for one transfer cycle |
| use_prog_i | input | 1 | 1: use timing_i; 0: use the built-in default byte |
| timing_i | input | 8 | Programmed timing: [7:4] active count, [3:0] recovery count |
| strobe_o | output | 1 | Transfer strobe, 1 during the active phase |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock pulse on the last recovery clock |

## Verification
The bench runs the five typical mode bytes with the programmed source selected. Their distinct nibble pairs show that the active and recovery lengths each follow their own field. It also runs bytes 0x00 and 0xFF to reach both ends of the field range. A run with the default source selected and a different byte on timing_i tells the mux apart from the raw input. Further runs change timing_i in the middle of a cycle, raise start while busy, and restart on the clock right after done. These show sampling at acceptance, the ignore rule, and the exact handover gap.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;

  // Phase of the transfer cycle
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_RECOVER = 2'd2
  } pio_phase_e;

  // Default nibble width of each timing field
  localparam int unsigned DEF_FIELD_W = 4;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
  parameter int unsigned        FIELD_W     = 4,
  parameter logic [2*FIELD_W-1:0] DEF_TIMING = 8'h5C
) (
  input  logic                 use_prog_i,
  input  logic [2*FIELD_W-1:0] timing_i,
  output logic [FIELD_W-1:0]   act_len_o,
  output logic [FIELD_W-1:0]   rec_len_o
);

  localparam int unsigned TIMING_W = 2 * FIELD_W;

  logic [TIMING_W-1:0] chosen;

  always_comb begin
    if (use_prog_i) begin
      chosen = timing_i;
    end else begin
      chosen = DEF_TIMING;
    end
    act_len_o = chosen[TIMING_W-1:FIELD_W];
    rec_len_o = chosen[FIELD_W-1:0];
  end

endmodule

// File: rtl/pio_phase_counter.sv
module pio_phase_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pio_strobe_fsm.sv
module pio_strobe_fsm
  import pio_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cnt_zero_i,
  output logic       accept_o,
  output logic       load_rec_o,
  output logic       dec_o,
  output logic       strobe_o,
  output logic       busy_o,
  output logic       done_o
);

  pio_phase_e phase_q;
  pio_phase_e phase_d;

  always_comb begin
    phase_d    = phase_q;
    accept_o   = 1'b0;
    load_rec_o = 1'b0;
    dec_o      = 1'b0;
    done_o     = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          phase_d  = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (cnt_zero_i) begin
          load_rec_o = 1'b1;
          phase_d    = ST_RECOVER;
        end else begin
          dec_o = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt_zero_i) begin
          done_o  = 1'b1;
          phase_d = ST_IDLE;
        end else begin
          dec_o = 1'b1;
        end
      end
      default: begin
        phase_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign strobe_o = (phase_q == ST_ACTIVE);
  assign busy_o   = (phase_q != ST_IDLE);

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int unsigned          FIELD_W     = DEF_FIELD_W,
  parameter logic [2*FIELD_W-1:0] DEF_TIMING  = 8'h5C,
  parameter int unsigned          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 use_prog_i,
  input  logic [2*FIELD_W-1:0] timing_i,
  output logic                 strobe_o,
  output logic                 busy_o,
  output logic                 done_o
);

  logic               rst_n_sync;
  logic [FIELD_W-1:0] act_len;
  logic [FIELD_W-1:0] rec_len;
  logic [FIELD_W-1:0] rec_q;
  logic [FIELD_W-1:0] cnt_load_val;
  logic               accept;
  logic               load_rec;
  logic               cnt_dec;
  logic               cnt_load;
  logic               cnt_zero;

  pio_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  pio_timing_select #(
    .FIELD_W    (FIELD_W),
    .DEF_TIMING (DEF_TIMING)
  ) u_sel (
    .use_prog_i (use_prog_i),
    .timing_i   (timing_i),
    .act_len_o  (act_len),
    .rec_len_o  (rec_len)
  );

  pio_strobe_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start_i    (start_i),
    .cnt_zero_i (cnt_zero),
    .accept_o   (accept),
    .load_rec_o (load_rec),
    .dec_o      (cnt_dec),
    .strobe_o   (strobe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // Recovery length is held from acceptance until the phase switch
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rec_q <= '0;
    end else if (accept) begin
      rec_q <= rec_len;
    end
  end

  always_comb begin
    cnt_load     = accept | load_rec;
    cnt_load_val = accept ? act_len : rec_q;
  end

  pio_phase_counter #(
    .CNT_W (FIELD_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic strobe_o,
  input logic busy_o,
  input logic done_o
);

  // R2: an accepted start raises strobe and busy on the next clock
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (strobe_o && busy_o));

  // R7: the strobe is only active inside a busy cycle
  p_strobe_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> busy_o);

  // R8: done only appears inside a cycle, after the strobe has fallen
  p_done_in_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && !strobe_o));

  // R8: done is a single-clock pulse and the block is idle afterwards
  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o && !strobe_o));

  // R4: the recovery phase follows the strobe; a falling strobe keeps busy
  p_recover_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> busy_o);

  // R7: busy only ends through a done pulse
  p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

endmodule

bind pio_strobe_gen pio_strobe_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .start_i  (start_i),
  .strobe_o (strobe_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] DEF_BYTE = 8'h5C;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       use_prog_i;
  logic [7:0] timing_i;
  logic       strobe_o;
  logic       busy_o;
  logic       done_o;

  int checks;
  int errors;
  logic [7:0] exp_q[$];

  pio_strobe_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .use_prog_i (use_prog_i),
    .timing_i   (timing_i),
    .strobe_o   (strobe_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: waits for idle, issues one start and pushes the expected byte
  task automatic issue(input bit prog, input logic [7:0] tbyte);
    while (busy_o) @(negedge clk);
    start_i    = 1'b1;
    use_prog_i = prog;
    timing_i   = tbyte;
    exp_q.push_back(prog ? tbyte : DEF_BYTE);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  // Monitor: measures each strobe cycle and compares with the scoreboard
  initial begin
    logic [7:0] e;
    int act_n;
    int rec_n;
    bit d;
    forever begin
      @(negedge clk);
      if (rst_n && strobe_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected cycle", 1, 0);
          e = 8'h00;
        end else begin
          e = exp_q.pop_front();
        end
        act_n = 0;
        while (strobe_o && act_n < 40) begin
          act_n++;
          check(busy_o === 1'b1, "R7 busy during strobe", busy_o, 1);
          @(negedge clk);
        end
        rec_n = 0;
        d = 1'b0;
        while (!d && rec_n < 40) begin
          rec_n++;
          d = done_o;
          if (strobe_o) check(1'b0, "R4 strobe in recovery", 1, 0);
          if (!d) @(negedge clk);
        end
        check(act_n == int'(e[7:4]) + 1, "R3 active length", act_n, int'(e[7:4]) + 1);
        check(rec_n == int'(e[3:0]) + 1, "R4 recovery length", rec_n, int'(e[3:0]) + 1);
        @(negedge clk);
        check(done_o === 1'b0, "R8 done single clock", done_o, 0);
        check(busy_o === 1'b0, "R8 idle after done", busy_o, 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    use_prog_i = 1'b0;
    timing_i   = 8'h00;
    repeat (3) @(negedge clk);
    check(strobe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 outputs in reset", {strobe_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(strobe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 outputs after release", {strobe_o, busy_o, done_o}, 0);

    // R2: strobe and busy rise on the clock after acceptance
    start_i = 1'b1; use_prog_i = 1'b1; timing_i = 8'h22;
    exp_q.push_back(8'h22);
    check(busy_o === 1'b0, "R2 idle before accept", busy_o, 0);
    @(negedge clk);
    start_i = 1'b0;
    check(strobe_o === 1'b1 && busy_o === 1'b1, "R2 strobe after accept",
          {strobe_o, busy_o}, 3);
    wait_done();
    @(negedge clk);

    // R3/R4: typical mode bytes, programmed source
    issue(1'b1, 8'h5C);
    issue(1'b1, 8'h37);
    issue(1'b1, 8'h33);
    issue(1'b1, 8'h22);
    issue(1'b1, 8'h20);

    // R9: zero fields and the full range
    issue(1'b1, 8'h00);
    issue(1'b1, 8'hFF);
    issue(1'b1, 8'h0F);

    // R5: default source ignores timing_i
    issue(1'b0, 8'h12);

    // R6: change timing_i and source mid-cycle
    issue(1'b1, 8'h31);
    timing_i   = 8'hF0;
    use_prog_i = 1'b0;
    wait_done();
    @(negedge clk);

    // R7: start while busy is ignored
    issue(1'b1, 8'h22);
    start_i  = 1'b1;
    timing_i = 8'h00;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (6) begin
      @(negedge clk);
      check(busy_o === 1'b0 && strobe_o === 1'b0, "R7 ignored start", busy_o, 0);
    end

    // R8: restart in the clock after done
    issue(1'b1, 8'h11);
    wait_done();
    @(negedge clk);
    check(busy_o === 1'b0, "R8 idle clock after done", busy_o, 0);
    start_i = 1'b1; use_prog_i = 1'b1; timing_i = 8'h10;
    exp_q.push_back(8'h10);
    @(negedge clk);
    start_i = 1'b0;
    check(strobe_o === 1'b1, "R8 restart two clocks after done", strobe_o, 1);
    wait_done();
    repeat (3) @(negedge clk);

    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule